// File: doc/BRIEF.md
# Microcoded Accumulator Processor Core

This block is a complete small processor. A single-bus datapath holds a program counter, an accumulator, an instruction register, a memory address register, an ALU operand latch and an ALU result latch. It is steered by a microprogrammed control unit. Instructions are `ADDR_W + 3` bits wide. The top three bits give the operation and the low `ADDR_W` bits give a data address. Memory has `2**ADDR_W` words of that width. Every architectural value (PC, ACC, memory words) is a full instruction-width word, and all arithmetic wraps modulo `2**(ADDR_W+3)`.

An instruction takes between four and eight clock cycles depending on its operation, and for a conditional branch on the accumulator value. The microprogram counter is brought out as an observation port. Each time it returns to zero, PC, ACC and memory hold exactly the state that an instruction-at-a-time model would hold after the same number of instructions.

A preload port writes memory words, so a program can be placed before reset is released. A separate combinational peek port reads any memory word.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it rises, `pc_o`, `acc_o` and `upc_o` are all zero. Reset does not clear memory.
- R2: The instruction executed is the memory word at address `pc_o mod 2**ADDR_W`. Its operation field is bits `[ADDR_W+2:ADDR_W]` and its address field is bits `[ADDR_W-1:0]`.
- R3: Operation 0 (branch-if-zero) sets PC to the whole instruction word when ACC is zero, and otherwise sets PC to PC+1. ACC and memory are unchanged.
- R4: Operation 1 (jump) sets PC to the whole instruction word. ACC and memory are unchanged.
- R5: Operation 2 sets ACC to ACC + mem[address] and operation 3 sets ACC to ACC - mem[address], both modulo `2**(ADDR_W+3)`. Both then set PC to PC+1.
- R6: Operation 4 loads mem[address] into ACC. Operation 5 writes ACC into mem[address]. Both set PC to PC+1.
- R7: Operations 6 and 7 set PC to PC+1 and leave ACC and memory unchanged.
- R8: Every PC increment wraps modulo `2**(ADDR_W+3)`, so all-ones becomes zero.
- R9: Counted from one visit of `upc_o == 0` to the next, an instruction takes the following number of cycles: branch-if-zero taken 5, branch-if-zero not taken 6, jump 4, add and subtract 8, load, store and operation 6 each take 6, and operation 7 takes 5.
- R10: PC changes only on the clock edge that returns the microprogram counter to zero. While `upc_o` is nonzero, `pc_o` is stable.
- R11: When `load_en` is high at a clock edge, `load_data` is written to memory word `load_addr`. A preload wins over a core store in the same cycle. `peek_data` shows memory word `peek_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the core registers |
| load_en | input | 1 | Preload write strobe |
| load_addr | input | ADDR_W | Preload word address |
| load_data | input | ADDR_W+3 | Preload word value |
| peek_addr | input | ADDR_W | Observation read address |
| peek_data | output | ADDR_W+3 | Memory word at `peek_addr` |
| pc_o | output | ADDR_W+3 | Program counter |
| acc_o | output | ADDR_W+3 | Accumulator |
| upc_o | output | 4 | Microprogram counter; zero marks an instruction boundary |

## Verification
Most internal faults show up at the next instruction boundary. A wrong dispatch or branch decision in the sequencer either changes the cycle count between two zero visits of `upc_o`, or leaves PC pointing at the wrong word, within four to eight cycles. A bad ALU result or a wrong register strobe corrupts ACC or a memory word. That corruption is visible at the boundary that ends the instruction, or when the affected word is next peeked or loaded. A PC that moves mid-instruction is visible on `pc_o` in the very cycle it happens.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

  localparam int UPC_W = 4;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_MEM, SRC_PC, SRC_ACC, SRC_IR, SRC_BUF
  } bus_src_e;

  typedef enum logic [1:0] {
    ALU_NONE, ALU_ADD, ALU_SUB, ALU_INC
  } alu_op_e;

  typedef enum logic [1:0] {
    NX_STEP, NX_DISPATCH, NX_IF_NZ, NX_GOTO
  } next_e;

  typedef struct packed {
    bus_src_e          src;
    logic              w_mem;
    logic              w_mar;
    logic              w_pc;
    logic              w_acc;
    logic              w_ir;
    logic              w_arg;
    alu_op_e           alu;
    next_e             nx;
    logic [UPC_W-1:0]  target;
  } uword_t;

  // write mask order: {mem, mar, pc, acc, ir, arg}
  function automatic uword_t mk(input bus_src_e s, input logic [5:0] wr,
                                input alu_op_e a, input next_e n,
                                input logic [UPC_W-1:0] t);
    uword_t u;
    u.src    = s;
    u.w_mem  = wr[5];
    u.w_mar  = wr[4];
    u.w_pc   = wr[3];
    u.w_acc  = wr[2];
    u.w_ir   = wr[1];
    u.w_arg  = wr[0];
    u.alu    = a;
    u.nx     = n;
    u.target = t;
    return u;
  endfunction

  // Microprogram store. Step 0..2 fetch and decode; step 3+op is the entry
  // point of each operation; steps 10..11 form the shared PC-increment tail.
  function automatic uword_t ucode(input logic [UPC_W-1:0] a);
    case (a)
      4'd0:  return mk(SRC_PC,   6'b010000, ALU_NONE, NX_STEP,     4'd0);
      4'd1:  return mk(SRC_MEM,  6'b000010, ALU_NONE, NX_STEP,     4'd0);
      4'd2:  return mk(SRC_IR,   6'b010000, ALU_NONE, NX_DISPATCH, 4'd0);
      4'd3:  return mk(SRC_NONE, 6'b000000, ALU_NONE, NX_IF_NZ,    4'd10);
      4'd4:  return mk(SRC_IR,   6'b001000, ALU_NONE, NX_GOTO,     4'd0);
      4'd5:  return mk(SRC_ACC,  6'b000001, ALU_NONE, NX_GOTO,     4'd12);
      4'd6:  return mk(SRC_ACC,  6'b000001, ALU_NONE, NX_GOTO,     4'd13);
      4'd7:  return mk(SRC_MEM,  6'b000100, ALU_NONE, NX_GOTO,     4'd10);
      4'd8:  return mk(SRC_ACC,  6'b100000, ALU_NONE, NX_GOTO,     4'd10);
      4'd9:  return mk(SRC_NONE, 6'b000000, ALU_NONE, NX_STEP,     4'd0);
      4'd10: return mk(SRC_PC,   6'b000000, ALU_INC,  NX_STEP,     4'd0);
      4'd11: return mk(SRC_BUF,  6'b001000, ALU_NONE, NX_GOTO,     4'd0);
      4'd12: return mk(SRC_MEM,  6'b000000, ALU_ADD,  NX_GOTO,     4'd14);
      4'd13: return mk(SRC_MEM,  6'b000000, ALU_SUB,  NX_STEP,     4'd0);
      4'd14: return mk(SRC_BUF,  6'b000100, ALU_NONE, NX_GOTO,     4'd10);
      default: return mk(SRC_NONE, 6'b000000, ALU_NONE, NX_GOTO,   4'd0);
    endcase
  endfunction

endpackage

// File: rtl/acc_cpu_useq.sv
`timescale 1ns/1ps
module acc_cpu_useq
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       opcode,
  input  logic             acc_nz,
  output uword_t           ctrl,
  output logic [UPC_W-1:0] upc
);

  localparam logic [UPC_W-1:0] OP_BASE = UPC_W'(3);

  logic [UPC_W-1:0] upc_q, upc_d;
  logic             take_branch;

  always_comb ctrl = ucode(upc_q);

  assign take_branch = (ctrl.nx == NX_IF_NZ) && acc_nz;

  always_comb begin
    case (ctrl.nx)
      NX_STEP:     upc_d = upc_q + 1'b1;
      NX_DISPATCH: upc_d = UPC_W'(opcode) + OP_BASE;
      NX_IF_NZ:    upc_d = take_branch ? ctrl.target : upc_q + 1'b1;
      default:     upc_d = ctrl.target;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) upc_q <= '0;
    else        upc_q <= upc_d;
  end

  assign upc = upc_q;

  a_r9_upc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    upc_q <= UPC_W'(14));

  a_r9_dispatch_to_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_q == UPC_W'(2)) |=> (upc_q == UPC_W'($past(opcode)) + OP_BASE));

  a_r3_zero_takes_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_q == UPC_W'(3) && !acc_nz) |=> (upc_q == UPC_W'(4)));

  a_r3_nonzero_skips: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_q == UPC_W'(3) && acc_nz) |=> (upc_q == UPC_W'(10)));

endmodule

// File: rtl/acc_cpu_mem.sv
`timescale 1ns/1ps
module acc_cpu_mem #(
  parameter int ADDR_W = 5,
  parameter int WORD_W = ADDR_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WORD_W-1:0] load_data,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [WORD_W-1:0] core_wdata,
  output logic [WORD_W-1:0] core_rdata,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [WORD_W-1:0] peek_data
);

  localparam int DEPTH = 2 ** ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic              wr_go;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;

  // preload has priority over a core store
  assign wr_go   = load_en || core_we;
  assign wr_addr = load_en ? load_addr : core_addr;
  assign wr_data = load_en ? load_data : core_wdata;

  always_ff @(posedge clk) begin
    if (wr_go) mem_q[wr_addr] <= wr_data;
  end

  assign core_rdata = mem_q[core_addr];
  assign peek_data  = mem_q[peek_addr];

  a_r11_preload_lands: assert property (@(posedge clk)
    load_en |=> (mem_q[$past(load_addr)] == $past(load_data)));

  a_r6_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we && !load_en) |=> (mem_q[$past(core_addr)] == $past(core_wdata)));

endmodule

// File: rtl/acc_cpu_datapath.sv
`timescale 1ns/1ps
module acc_cpu_datapath
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int WORD_W = ADDR_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  uword_t            ctrl,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [2:0]        opcode,
  output logic              acc_nz,
  output logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] acc
);

  function automatic logic [WORD_W-1:0] add_wrap(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [WORD_W-1:0] sub_wrap(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    return a - b;
  endfunction

  function automatic logic [WORD_W-1:0] inc_wrap(input logic [WORD_W-1:0] a);
    return a + 1'b1;
  endfunction

  logic [WORD_W-1:0] mar_q, pc_q, acc_q, ir_q, arg_q, buf_q;
  logic [WORD_W-1:0] bus, alu_y;
  logic              buf_we;

  always_comb begin
    case (ctrl.src)
      SRC_MEM: bus = mem_rdata;
      SRC_PC:  bus = pc_q;
      SRC_ACC: bus = acc_q;
      SRC_IR:  bus = ir_q;
      SRC_BUF: bus = buf_q;
      default: bus = '0;
    endcase
  end

  always_comb begin
    case (ctrl.alu)
      ALU_ADD: alu_y = add_wrap(arg_q, bus);
      ALU_SUB: alu_y = sub_wrap(arg_q, bus);
      ALU_INC: alu_y = inc_wrap(bus);
      default: alu_y = bus;
    endcase
  end

  assign buf_we = (ctrl.alu != ALU_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar_q <= '0;
      pc_q  <= '0;
      acc_q <= '0;
      ir_q  <= '0;
      arg_q <= '0;
      buf_q <= '0;
    end else begin
      if (ctrl.w_mar) mar_q <= bus;
      if (ctrl.w_pc)  pc_q  <= bus;
      if (ctrl.w_acc) acc_q <= bus;
      if (ctrl.w_ir)  ir_q  <= bus;
      if (ctrl.w_arg) arg_q <= bus;
      if (buf_we)     buf_q <= alu_y;
    end
  end

  assign mem_we    = ctrl.w_mem;
  assign mem_addr  = mar_q[ADDR_W-1:0];
  assign mem_wdata = bus;
  assign opcode    = ir_q[ADDR_W+2:ADDR_W];
  assign acc_nz    = (acc_q != '0);
  assign pc        = pc_q;
  assign acc       = acc_q;

  a_r6_acc_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_q) |-> $past(ctrl.w_acc));

  a_r5_arg_from_acc: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.w_arg |=> (arg_q == $past(acc_q)));

endmodule

// File: rtl/acc_cpu_core.sv
`timescale 1ns/1ps
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int WORD_W = ADDR_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WORD_W-1:0] load_data,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [WORD_W-1:0] peek_data,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] acc_o,
  output logic [UPC_W-1:0]  upc_o
);

  uword_t            ctrl;
  logic [UPC_W-1:0]  upc;
  logic [2:0]        opcode;
  logic              acc_nz;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_wdata, mem_rdata;
  logic [WORD_W-1:0] pc, acc;

  acc_cpu_useq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (opcode),
    .acc_nz (acc_nz),
    .ctrl   (ctrl),
    .upc    (upc)
  );

  acc_cpu_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .opcode    (opcode),
    .acc_nz    (acc_nz),
    .pc        (pc),
    .acc       (acc)
  );

  acc_cpu_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .load_addr  (load_addr),
    .load_data  (load_data),
    .core_we    (mem_we),
    .core_addr  (mem_addr),
    .core_wdata (mem_wdata),
    .core_rdata (mem_rdata),
    .peek_addr  (peek_addr),
    .peek_data  (peek_data)
  );

  assign pc_o  = pc;
  assign acc_o = acc;
  assign upc_o = upc;

  a_r10_pc_held_mid_instr: assert property (@(posedge clk) disable iff (!rst_n)
    (upc != '0) |-> $stable(pc));

  a_r1_boundary_after_reset: assert property (@(posedge clk)
    !rst_n |=> (upc == '0 && pc == '0 && acc == '0));

endmodule

// File: tb/acc_cpu_core_bench.sv
`timescale 1ns/1ps
module acc_cpu_core_bench;

  localparam int AW    = 5;
  localparam int WW    = AW + 3;
  localparam int DEPTH = 2 ** AW;

  // preload vectors: {address, word}; word = {op[2:0], addr[4:0]}
  localparam int NPROG = 23;
  localparam logic [AW+WW-1:0] PROG [NPROG] = '{
    {5'd0,  8'h98},  // load 24
    {5'd1,  8'h59},  // add 25  (F0+E5 wraps)
    {5'd2,  8'h7C},  // sub 28
    {5'd3,  8'h14},  // branch-if-zero 20 (not taken)
    {5'd4,  8'hBB},  // store 27
    {5'd5,  8'hC0},  // op 6
    {5'd6,  8'hE0},  // op 7
    {5'd7,  8'h7B},  // sub 27 -> zero
    {5'd8,  8'h0A},  // branch-if-zero 10 (taken)
    {5'd9,  8'hE0},
    {5'd10, 8'h7A},  // sub 26 (0 - C1 wraps)
    {5'd11, 8'h5A},  // add 26 (wraps to 0)
    {5'd12, 8'h2E},  // jump, pc = 0x2E, fetch word 14
    {5'd13, 8'hC0},
    {5'd14, 8'h9C},  // load 28
    {5'd15, 8'hBD},  // store 29
    {5'd16, 8'h20},  // jump, pc = 0x20, fetch word 0
    {5'd24, 8'hF0},
    {5'd25, 8'hE5},
    {5'd26, 8'hC1},
    {5'd27, 8'h00},
    {5'd28, 8'hC4},
    {5'd29, 8'h00}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [WW-1:0] load_data = '0;
  logic [AW-1:0] peek_addr = '0;
  logic [WW-1:0] peek_data;
  logic [WW-1:0] pc_o, acc_o;
  logic [3:0]    upc_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [WW-1:0] m_mem [DEPTH];
  logic [WW-1:0] m_pc, m_acc;

  always #10 clk = ~clk;

  acc_cpu_core #(.ADDR_W(AW)) u_acc_cpu_core (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .peek_addr(peek_addr), .peek_data(peek_data),
    .pc_o(pc_o), .acc_o(acc_o), .upc_o(upc_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [AW-1:0] a, input logic [WW-1:0] d);
    @(negedge clk);
    load_en = 1'b1; load_addr = a; load_data = d;
    m_mem[a] = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [WW-1:0] d);
    peek_addr = a;
    #1;
    d = peek_data;
  endtask

  // one architectural step of the reference model; returns expected cycles
  task automatic model_step(output int lat, output int op, output int st_addr);
    logic [WW-1:0] inst;
    logic [AW-1:0] a;
    inst = m_mem[m_pc[AW-1:0]];
    op   = int'(inst[WW-1:AW]);
    a    = inst[AW-1:0];
    st_addr = -1;
    case (op)
      0: begin lat = (m_acc == '0) ? 5 : 6;
               m_pc = (m_acc == '0) ? inst : m_pc + 8'd1; end
      1: begin lat = 4; m_pc = inst; end
      2: begin lat = 8; m_acc = m_acc + m_mem[a]; m_pc = m_pc + 8'd1; end
      3: begin lat = 8; m_acc = m_acc - m_mem[a]; m_pc = m_pc + 8'd1; end
      4: begin lat = 6; m_acc = m_mem[a]; m_pc = m_pc + 8'd1; end
      5: begin lat = 6; m_mem[a] = m_acc; st_addr = int'(a); m_pc = m_pc + 8'd1; end
      6: begin lat = 6; m_pc = m_pc + 8'd1; end
      default: begin lat = 5; m_pc = m_pc + 8'd1; end
    endcase
  endtask

  // called at a negedge where upc_o == 0; runs to the next boundary
  task automatic run_instr();
    int lat, op, st_addr, cnt;
    logic [WW-1:0] pc0, d;
    bit held;
    string tg;
    model_step(lat, op, st_addr);
    case (op)
      0: tg = "R3"; 1: tg = "R4"; 2, 3: tg = "R5";
      4, 5: tg = "R6"; default: tg = "R7";
    endcase
    pc0 = pc_o; held = 1'b1; cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (upc_o != 4'd0 && pc_o != pc0) held = 1'b0;
    end while (upc_o != 4'd0 && cnt < 20);
    chk(pc_o == m_pc, {"R2/", tg, " pc"}, int'(pc_o), int'(m_pc));
    chk(acc_o == m_acc, {tg, " acc"}, int'(acc_o), int'(m_acc));
    chk(cnt == lat, "R9 cycles per instruction", cnt, lat);
    chk(held, "R10 pc stable mid-instruction", int'(held), 1);
    if (st_addr >= 0) begin
      peek(AW'(st_addr), d);
      chk(d == m_mem[st_addr], "R6 stored word", int'(d), int'(m_mem[st_addr]));
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    logic [WW-1:0] d;
    // preload during reset
    for (int k = 0; k < DEPTH; k++) preload(AW'(k), 8'hE0);
    for (int k = 0; k < NPROG; k++)
      preload(PROG[k][AW+WW-1:WW], PROG[k][WW-1:0]);
    peek(5'd25, d);
    chk(d == 8'hE5, "R11 preload visible on peek", int'(d), 'hE5);
    chk(pc_o == '0 && acc_o == '0 && upc_o == '0, "R1 state in reset",
        int'({pc_o, acc_o}), 0);
    m_pc = '0; m_acc = '0;
    rst_n = 1'b1;
    chk(upc_o == '0, "R1 upc at release", int'(upc_o), 0);

    for (int i = 0; i < 40; i++) run_instr();

    for (int k = 0; k < DEPTH; k++) begin
      peek(AW'(k), d);
      chk(d == m_mem[k], "R6/R11 memory sweep", int'(d), int'(m_mem[k]));
    end

    // reset in the middle of an instruction
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(pc_o == '0, "R1 pc after mid-run reset", int'(pc_o), 0);
    chk(acc_o == '0, "R1 acc after mid-run reset", int'(acc_o), 0);
    chk(upc_o == '0, "R1 upc after mid-run reset", int'(upc_o), 0);
    peek(5'd27, d);
    chk(d == m_mem[27], "R1 memory kept through reset", int'(d), int'(m_mem[27]));

    // PC wrap: memory full of op-7 words, run past the top of the PC range
    for (int k = 0; k < DEPTH; k++) preload(AW'(k), 8'hE0);
    m_pc = '0; m_acc = '0;
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) run_instr();
    chk(pc_o == '0, "R8 pc wrapped to zero", int'(pc_o), 0);
    for (int i = 0; i < 2; i++) run_instr();
    chk(pc_o == 8'd2, "R8 pc counts on after wrap", int'(pc_o), 2);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule